// File: doc/BRIEF.md
# Short Immediate Shift Rotate Unit

This block runs one class of single-word instructions against a private file of eight 16-bit registers and a set of four condition flags. The instruction carries its operand in a 4-bit field. That field is biased by one, so it stands for a constant or a step count from 1 to 16. Four instructions combine that constant with a register: add, subtract, bit clear and load. Eight more instructions move bits. They rotate through the carry flag or shift arithmetically, either on one register (17-bit rotation) or on a register pair (33-bit rotation, 32-bit shift). In a pair the named register holds the low word and the next register up holds the high word, wrapping from R7 to R0.

A controller presents `instr` with a one-cycle `start` pulse while `busy` is low. The constant operations finish after one clock. The bit-moving operations advance one bit position per clock, so they take as many clocks as the effective count. The end of each instruction is marked by a one-cycle `done`. A load port fills registers and the carry flag while the unit is idle.

The controller has four states: IDLE, ARITH, SHIFT and FINISH. Its transitions are:
- IDLE→ARITH on start with the constant group.
- IDLE→SHIFT on start with either bit-moving group.
- IDLE→FINISH on start with an unrecognised major opcode.
- ARITH→FINISH always.
- SHIFT→SHIFT while more than one step remains.
- SHIFT→FINISH on the last step.
- FINISH→IDLE always.

Top module: `simm_shift_unit`

## Requirements
- R1: Instruction fields are decoded as follows. Bits 15:9 give the major opcode: 0000100 is the constant group, 1000100 is the single-register group and 1000111 is the pair group. Bits 8:6 name the register, bits 5:4 pick the sub-operation and bits 3:0 hold the count. The effective constant or count is the count field plus one (1..16), so a load with field 0 writes 1 and a load with field 15 writes 16.
- R2: Constant sub-op 0 adds the constant to the register. N is the result's bit 15, Z means the result is zero, C is the carry out of bit 15 and V is signed overflow.
- R3: Constant sub-op 1 subtracts the constant from the register. C is set when a borrow occurs (unsigned register < constant), V is signed overflow, and N and Z follow the result.
- R4: Constant sub-op 2 clears in the register the bits set in the constant, and sub-op 3 loads the constant into the register. Both clear V, keep C, and set N and Z from the result.
- R5: Single-register sub-op 0 rotates the register right and sub-op 1 rotates it left, through carry, as a 17-bit ring, by the effective count.
- R6: Single-register sub-op 2 shifts right arithmetically, copying bit 15 in. Sub-op 3 shifts left and fills with zeros. In both, C takes the last bit shifted out.
- R7: The pair group applies the same four sub-ops to the 32-bit value {R(n+1 mod 8), Rn}. The rotates form a 33-bit ring with carry. The high word goes back to R(n+1 mod 8), which is R0 when n is 7.
- R8: After a bit-moving operation, N is the most significant bit of the result (bit 31 for pairs), Z means the whole result is zero, C is the last bit out, and V equals N XOR C.
- R9: With start accepted at edge t, done is high for exactly one cycle. It begins after edge t+1 for the constant group and after edge t+count for the bit-moving groups, and the new register and flag values are visible while done is high.
- R10: An unrecognised major opcode raises done after the accepting edge itself and changes no register and no flag.
- R11: While busy is high, start is ignored. Busy falls the cycle after done.
- R12: Reset clears all registers, all flags, busy and done. An operation changes only its target register (and the pair partner), and only at its final edge. The load port writes a register or the carry flag only while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin the instruction on `instr` (idle only) |
| instr | input | 16 | Instruction word |
| ld_en | input | 1 | Write `ld_data` into register `ld_sel` while idle |
| ld_sel | input | 3 | Register index for the load port |
| ld_data | input | 16 | Load data |
| ld_carry_en | input | 1 | Write `ld_carry` into the carry flag while idle |
| ld_carry | input | 1 | Carry load value |
| busy | output | 1 | An instruction is in progress |
| done | output | 1 | One-cycle completion pulse |
| regs_flat | output | 128 | Register file, Rn in bits 16n+15:16n |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_v | output | 1 | Overflow flag |
| flag_c | output | 1 | Carry flag |

## Verification
Every sub-op of all three groups is swept over all sixteen count values, on registers 0, 5 and 7, with both carry values. Three register images are used:
- Values just under 0x7FFF separate correct overflow and carry-out from wrong ones.
- Small values, including zero, expose borrow and the zero flag.
- Mixed-sign values show whether right shifts copy the sign and whether rotates take the carry in at the right end.

Register 7 in the pair group checks the wrap of the partner to R0, and the count extremes 1 and 16 check the bias. Further runs cover unrecognised opcodes, a start pulse issued mid-operation, and counting clocks from start to done.

// File: rtl/simm_pkg.sv
package simm_pkg;

    // Instruction format (field positions are fixed by the encoding)
    localparam int INSTR_W      = 16;
    localparam int MAJ_W        = 7;
    localparam int REG_FIELD_W  = 3;
    localparam int CNT_FIELD_W  = 4;
    localparam int AMT_W        = CNT_FIELD_W + 1;

    localparam logic [MAJ_W-1:0] MAJ_CONST = 7'b0000100;
    localparam logic [MAJ_W-1:0] MAJ_SGL   = 7'b1000100;
    localparam logic [MAJ_W-1:0] MAJ_PAIR  = 7'b1000111;

    // sub-op codes, constant group
    localparam logic [1:0] SUBOP_ADD = 2'd0;
    localparam logic [1:0] SUBOP_SUB = 2'd1;
    localparam logic [1:0] SUBOP_BIC = 2'd2;
    localparam logic [1:0] SUBOP_LDK = 2'd3;

    // sub-op codes, bit-moving groups
    localparam logic [1:0] SUBOP_ROR = 2'd0;
    localparam logic [1:0] SUBOP_ROL = 2'd1;
    localparam logic [1:0] SUBOP_ASR = 2'd2;
    localparam logic [1:0] SUBOP_ASL = 2'd3;

    typedef enum logic [1:0] {
        GRP_CONST = 2'd0,
        GRP_SGL   = 2'd1,
        GRP_PAIR  = 2'd2,
        GRP_NONE  = 2'd3
    } grp_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ARITH  = 2'd1,
        ST_SHIFT  = 2'd2,
        ST_FINISH = 2'd3
    } state_e;

    typedef struct packed {
        logic n;
        logic z;
        logic v;
        logic c;
    } flags_t;

endpackage

// File: rtl/simm_decode.sv
module simm_decode
    import simm_pkg::*;
#(
    parameter int NREGS  = 8,
    parameter int RIDX_W = $clog2(NREGS)
) (
    input  logic [INSTR_W-1:0] instr,
    output grp_e               grp,
    output logic [1:0]         sub,
    output logic [RIDX_W-1:0]  ridx,
    output logic [RIDX_W-1:0]  ridx_hi,
    output logic [AMT_W-1:0]   amount
);

    localparam logic [RIDX_W-1:0] LAST_IDX = RIDX_W'(NREGS - 1);

    logic [MAJ_W-1:0]       major;
    logic [REG_FIELD_W-1:0] reg_field;
    logic [CNT_FIELD_W-1:0] cnt_field;

    assign major     = instr[INSTR_W-1 -: MAJ_W];
    assign reg_field = instr[8:6];
    assign sub       = instr[5:4];
    assign cnt_field = instr[CNT_FIELD_W-1:0];

    always_comb begin
        case (major)
            MAJ_CONST: grp = GRP_CONST;
            MAJ_SGL:   grp = GRP_SGL;
            MAJ_PAIR:  grp = GRP_PAIR;
            default:   grp = GRP_NONE;
        endcase
    end

    assign ridx    = RIDX_W'(reg_field);
    assign ridx_hi = (ridx == LAST_IDX) ? '0 : ridx + 1'b1;
    assign amount  = AMT_W'(cnt_field) + AMT_W'(1);

endmodule

// File: rtl/simm_const_alu.sv
module simm_const_alu
    import simm_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] k,
    input  logic [1:0]   sub,
    input  logic         c_in,
    output logic [W-1:0] res,
    output flags_t       fl
);

    logic [W:0] wide;
    logic       ovf;
    logic       cy;

    always_comb begin
        wide = '0;
        res  = '0;
        ovf  = 1'b0;
        cy   = c_in;
        case (sub)
            SUBOP_ADD: begin
                wide = {1'b0, a} + {1'b0, k};
                res  = wide[W-1:0];
                cy   = wide[W];
                ovf  = (a[W-1] == k[W-1]) && (res[W-1] != a[W-1]);
            end
            SUBOP_SUB: begin
                wide = {1'b0, a} - {1'b0, k};
                res  = wide[W-1:0];
                cy   = wide[W];
                ovf  = (a[W-1] != k[W-1]) && (res[W-1] != a[W-1]);
            end
            SUBOP_BIC: res = a & ~k;
            default:   res = k;
        endcase
        fl.n = res[W-1];
        fl.z = (res == '0);
        fl.v = ovf;
        fl.c = cy;
    end

endmodule

// File: rtl/simm_step.sv
module simm_step
    import simm_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [W-1:0] v,
    input  logic [1:0]   sub,
    input  logic         c_in,
    output logic [W-1:0] v_next,
    output logic         c_next
);

    // one bit position per call; the controller repeats it count times
    always_comb begin
        case (sub)
            SUBOP_ROR: begin
                c_next = v[0];
                v_next = {c_in, v[W-1:1]};
            end
            SUBOP_ROL: begin
                c_next = v[W-1];
                v_next = {v[W-2:0], c_in};
            end
            SUBOP_ASR: begin
                c_next = v[0];
                v_next = {v[W-1], v[W-1:1]};
            end
            default: begin
                c_next = v[W-1];
                v_next = {v[W-2:0], 1'b0};
            end
        endcase
    end

endmodule

// File: rtl/simm_regfile.sv
module simm_regfile #(
    parameter int DATA_W = 16,
    parameter int NREGS  = 8,
    parameter int RIDX_W = $clog2(NREGS)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wa_en,
    input  logic [RIDX_W-1:0]       wa_idx,
    input  logic [DATA_W-1:0]       wa_d,
    input  logic                    wb_en,
    input  logic [RIDX_W-1:0]       wb_idx,
    input  logic [DATA_W-1:0]       wb_d,
    input  logic                    ld_en,
    input  logic [RIDX_W-1:0]       ld_idx,
    input  logic [DATA_W-1:0]       ld_d,
    output logic [DATA_W*NREGS-1:0] regs_flat
);

    for (genvar i = 0; i < NREGS; i++) begin : g_reg
        logic [DATA_W-1:0] q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                q <= '0;
            end else if (wa_en && wa_idx == RIDX_W'(i)) begin
                q <= wa_d;
            end else if (wb_en && wb_idx == RIDX_W'(i)) begin
                q <= wb_d;
            end else if (ld_en && ld_idx == RIDX_W'(i)) begin
                q <= ld_d;
            end
        end

        assign regs_flat[i*DATA_W +: DATA_W] = q;
    end

endmodule

// File: rtl/simm_shift_unit.sv
module simm_shift_unit
    import simm_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int NREGS  = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         start,
    input  logic [INSTR_W-1:0]           instr,
    input  logic                         ld_en,
    input  logic [$clog2(NREGS)-1:0]     ld_sel,
    input  logic [DATA_W-1:0]            ld_data,
    input  logic                         ld_carry_en,
    input  logic                         ld_carry,
    output logic                         busy,
    output logic                         done,
    output logic [DATA_W*NREGS-1:0]      regs_flat,
    output logic                         flag_n,
    output logic                         flag_z,
    output logic                         flag_v,
    output logic                         flag_c
);

    localparam int RIDX_W = $clog2(NREGS);
    localparam int PAIR_W = 2 * DATA_W;
    localparam int REGS_W = DATA_W * NREGS;

    state_e state_q, state_d;

    // decoded fields of the incoming word
    grp_e              dec_grp;
    logic [1:0]        dec_sub;
    logic [RIDX_W-1:0] dec_idx, dec_idx_hi;
    logic [AMT_W-1:0]  dec_amt;

    // latched instruction context
    grp_e              grp_q;
    logic [1:0]        sub_q;
    logic [RIDX_W-1:0] idx_q, idx_hi_q;
    logic [AMT_W-1:0]  amt_q;
    logic [AMT_W-1:0]  rem_q;
    logic [PAIR_W-1:0] acc_q;
    logic              cy_q;

    flags_t flags_q;

    logic [DATA_W-1:0] rf_view [NREGS];
    logic              accept;
    logic              arith_fire;
    logic              shift_last;

    logic [DATA_W-1:0] alu_res;
    flags_t            alu_fl;

    logic [DATA_W-1:0] sgl_v;
    logic              sgl_c;
    logic [PAIR_W-1:0] pair_v;
    logic              pair_c;
    logic [PAIR_W-1:0] step_v;
    logic              step_c;
    flags_t            shf_fl;

    simm_decode #(.NREGS(NREGS), .RIDX_W(RIDX_W)) u_dec (
        .instr   (instr),
        .grp     (dec_grp),
        .sub     (dec_sub),
        .ridx    (dec_idx),
        .ridx_hi (dec_idx_hi),
        .amount  (dec_amt)
    );

    for (genvar i = 0; i < NREGS; i++) begin : g_view
        assign rf_view[i] = regs_flat[i*DATA_W +: DATA_W];
    end

    assign accept     = start && (state_q == ST_IDLE);
    assign arith_fire = (state_q == ST_ARITH);
    assign shift_last = (state_q == ST_SHIFT) && (rem_q == AMT_W'(1));

    simm_const_alu #(.W(DATA_W)) u_alu (
        .a    (rf_view[idx_q]),
        .k    (DATA_W'(amt_q)),
        .sub  (sub_q),
        .c_in (flags_q.c),
        .res  (alu_res),
        .fl   (alu_fl)
    );

    simm_step #(.W(DATA_W)) u_step_sgl (
        .v      (acc_q[DATA_W-1:0]),
        .sub    (sub_q),
        .c_in   (cy_q),
        .v_next (sgl_v),
        .c_next (sgl_c)
    );

    simm_step #(.W(PAIR_W)) u_step_pair (
        .v      (acc_q),
        .sub    (sub_q),
        .c_in   (cy_q),
        .v_next (pair_v),
        .c_next (pair_c)
    );

    always_comb begin
        if (grp_q == GRP_PAIR) begin
            step_v   = pair_v;
            step_c   = pair_c;
            shf_fl.n = pair_v[PAIR_W-1];
            shf_fl.z = (pair_v == '0);
        end else begin
            step_v   = {acc_q[PAIR_W-1:DATA_W], sgl_v};
            step_c   = sgl_c;
            shf_fl.n = sgl_v[DATA_W-1];
            shf_fl.z = (sgl_v == '0);
        end
        shf_fl.c = step_c;
        shf_fl.v = shf_fl.n ^ step_c;
    end

    simm_regfile #(.DATA_W(DATA_W), .NREGS(NREGS), .RIDX_W(RIDX_W)) u_rf (
        .clk       (clk),
        .rst_n     (rst_n),
        .wa_en     (arith_fire || shift_last),
        .wa_idx    (idx_q),
        .wa_d      (arith_fire ? alu_res : step_v[DATA_W-1:0]),
        .wb_en     (shift_last && (grp_q == GRP_PAIR)),
        .wb_idx    (idx_hi_q),
        .wb_d      (step_v[PAIR_W-1:DATA_W]),
        .ld_en     (ld_en && (state_q == ST_IDLE)),
        .ld_idx    (ld_sel),
        .ld_d      (ld_data),
        .regs_flat (regs_flat)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    case (dec_grp)
                        GRP_CONST: state_d = ST_ARITH;
                        GRP_SGL,
                        GRP_PAIR:  state_d = ST_SHIFT;
                        default:   state_d = ST_FINISH;
                    endcase
                end
            end
            ST_ARITH:  state_d = ST_FINISH;
            ST_SHIFT:  if (rem_q == AMT_W'(1)) state_d = ST_FINISH;
            ST_FINISH: state_d = ST_IDLE;
        endcase
    end

    // instruction context and shift accumulator
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            grp_q    <= GRP_NONE;
            sub_q    <= '0;
            idx_q    <= '0;
            idx_hi_q <= '0;
            amt_q    <= '0;
            rem_q    <= '0;
            acc_q    <= '0;
            cy_q     <= 1'b0;
        end else if (accept) begin
            grp_q    <= dec_grp;
            sub_q    <= dec_sub;
            idx_q    <= dec_idx;
            idx_hi_q <= dec_idx_hi;
            amt_q    <= dec_amt;
            rem_q    <= dec_amt;
            acc_q    <= {rf_view[dec_idx_hi], rf_view[dec_idx]};
            cy_q     <= flags_q.c;
        end else if (state_q == ST_SHIFT) begin
            acc_q    <= step_v;
            cy_q     <= step_c;
            rem_q    <= rem_q - AMT_W'(1);
        end
    end

    // condition flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags_q <= '0;
        end else if (arith_fire) begin
            flags_q <= alu_fl;
        end else if (shift_last) begin
            flags_q <= shf_fl;
        end else if (ld_carry_en && (state_q == ST_IDLE)) begin
            flags_q.c <= ld_carry;
        end
    end

    // outputs
    always_comb begin
        busy   = (state_q != ST_IDLE);
        done   = (state_q == ST_FINISH);
        flag_n = flags_q.n;
        flag_z = flags_q.z;
        flag_v = flags_q.v;
        flag_c = flags_q.c;
    end

endmodule

// File: rtl/simm_checker.sv
module simm_checker
    import simm_pkg::*;
#(
    parameter int REGS_W = 128
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              done,
    input logic [REGS_W-1:0] regs_flat,
    input logic              flag_n,
    input logic              flag_z,
    input logic              flag_v,
    input logic              flag_c,
    input state_e            st,
    input grp_e              grp,
    input logic [1:0]        sub
);

    AST_DONE_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R9

    AST_ARITH_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_ARITH) |=> done); // R9

    AST_IDLE_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy); // R11

    AST_REGS_HOLD_MIDOP: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> (done || $stable(regs_flat))); // R12

    AST_SHIFT_V_RULE: assert property (@(posedge clk) disable iff (!rst_n)
        (done && (grp == GRP_SGL || grp == GRP_PAIR)) |-> (flag_v == (flag_n ^ flag_c))); // R8

    AST_LOADK_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (done && grp == GRP_CONST && sub == SUBOP_LDK) |-> (!flag_n && !flag_z && !flag_v)); // R4

endmodule

bind simm_shift_unit simm_checker #(.REGS_W(REGS_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .done      (done),
    .regs_flat (regs_flat),
    .flag_n    (flag_n),
    .flag_z    (flag_z),
    .flag_v    (flag_v),
    .flag_c    (flag_c),
    .st        (state_q),
    .grp       (grp_q),
    .sub       (sub_q)
);

// File: tb/sim_simm_shift_unit.sv
module sim_simm_shift_unit;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [15:0]  instr = '0;
    logic         ld_en = 1'b0;
    logic [2:0]   ld_sel = '0;
    logic [15:0]  ld_data = '0;
    logic         ld_carry_en = 1'b0;
    logic         ld_carry = 1'b0;
    logic         busy, done;
    logic [127:0] regs_flat;
    logic         flag_n, flag_z, flag_v, flag_c;

    int n_chk = 0;
    int n_bad = 0;

    // bench-side architectural model
    logic [15:0] m [8];
    logic [15:0] e [8];
    logic        mn = 1'b0, mz = 1'b0, mv = 1'b0, mc = 1'b0;
    logic        en, ez, ev, ec;

    always #10 clk = ~clk;

    simm_shift_unit u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .instr       (instr),
        .ld_en       (ld_en),
        .ld_sel      (ld_sel),
        .ld_data     (ld_data),
        .ld_carry_en (ld_carry_en),
        .ld_carry    (ld_carry),
        .busy        (busy),
        .done        (done),
        .regs_flat   (regs_flat),
        .flag_n      (flag_n),
        .flag_z      (flag_z),
        .flag_v      (flag_v),
        .flag_c      (flag_c)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] pattern(input int p, input int i);
        case (p)
            0:       return 16'h7FF8 + 16'(i);
            1:       return 16'(i);
            default: return 16'hA5C3 ^ 16'(i << 5);
        endcase
    endfunction

    task automatic load_reg(input int i, input logic [15:0] d);
        @(negedge clk);
        ld_en = 1'b1; ld_sel = 3'(i); ld_data = d;
        @(negedge clk);
        ld_en = 1'b0;
        m[i] = d;
    endtask

    task automatic load_carry(input logic c);
        @(negedge clk);
        ld_carry_en = 1'b1; ld_carry = c;
        @(negedge clk);
        ld_carry_en = 1'b0;
        mc = c;
    endtask

    function automatic logic [15:0] mk_instr(input int grp, input int r, input int sub, input int cnt);
        logic [6:0] maj;
        case (grp)
            0:       maj = 7'b0000100;
            1:       maj = 7'b1000100;
            default: maj = 7'b1000111;
        endcase
        return {maj, 3'(r), 2'(sub), 4'(cnt)};
    endfunction

    // expected result of one instruction, computed from the requirements
    task automatic model(input int grp, input int r, input int sub, input int cnt);
        int          amt, w, hi;
        logic [63:0] val, b, mask, m1, res;
        logic [16:0] s17;
        logic [15:0] a, k, r16;
        for (int i = 0; i < 8; i++) e[i] = m[i];
        amt = cnt + 1;
        hi  = (r + 1) % 8;
        if (grp == 0) begin
            a = m[r]; k = 16'(amt);
            ev = 1'b0; ec = mc; r16 = '0;
            case (sub)
                0: begin s17 = {1'b0, a} + {1'b0, k}; r16 = s17[15:0]; ec = s17[16];
                         ev = !a[15] && r16[15]; end
                1: begin r16 = a - k; ec = (a < k); ev = a[15] && !r16[15]; end
                2: r16 = a & ~k;
                default: r16 = k;
            endcase
            en = r16[15]; ez = (r16 == 16'd0);
            e[r] = r16;
        end else begin
            w    = (grp == 1) ? 16 : 32;
            mask = (64'd1 << w) - 64'd1;
            m1   = (64'd1 << (w + 1)) - 64'd1;
            val  = (grp == 1) ? {48'd0, m[r]} : {32'd0, m[hi], m[r]};
            b    = ({63'd0, mc} << w) | val;
            res  = '0; ec = 1'b0;
            case (sub)
                0: begin b = ((b >> amt) | (b << (w + 1 - amt))) & m1; ec = b[w]; res = b & mask; end
                1: begin b = ((b << amt) | (b >> (w + 1 - amt))) & m1; ec = b[w]; res = b & mask; end
                2: begin
                    ec  = val[amt-1];
                    res = val >> amt;
                    if (val[w-1]) res = res | (mask & ~(mask >> amt));
                end
                default: begin ec = val[w-amt]; res = (val << amt) & mask; end
            endcase
            en = res[w-1]; ez = (res == 64'd0); ev = en ^ ec;
            e[r] = res[15:0];
            if (grp == 2) e[hi] = res[31:16];
        end
    endtask

    // issue one word, return clocks from accepting edge to done
    task automatic issue(input logic [15:0] w, output int lat);
        @(negedge clk);
        instr = w; start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        lat = 0;
        while (!done && lat < 40) begin
            @(negedge clk);
            lat++;
        end
    endtask

    task automatic compare_all(input string tgt, input int r, input int hi, input bit pair, input string freq);
        for (int i = 0; i < 8; i++) begin
            if (i == r)
                check(tgt, 32'(regs_flat[i*16 +: 16]), 32'(e[i]));
            else if (pair && i == hi)
                check("R7 partner", 32'(regs_flat[i*16 +: 16]), 32'(e[i]));
            else
                check("R12 untouched", 32'(regs_flat[i*16 +: 16]), 32'(e[i]));
        end
        check(freq, {28'd0, flag_n, flag_z, flag_v, flag_c}, {28'd0, en, ez, ev, ec});
    endtask

    task automatic commit();
        for (int i = 0; i < 8; i++) m[i] = e[i];
        mn = en; mz = ez; mv = ev; mc = ec;
    endtask

    initial begin : watchdog
        #(20 * 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        int lat;
        int rsel[3];
        string tgt, freq;
        rsel[0] = 0; rsel[1] = 5; rsel[2] = 7;
        for (int i = 0; i < 8; i++) m[i] = '0;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12 reset state
        check("R12 reset regs", {31'd0, regs_flat == 128'd0}, 32'd1);
        check("R12 reset flags", {28'd0, flag_n, flag_z, flag_v, flag_c}, 32'd0);
        check("R12 reset busy/done", {30'd0, busy, done}, 32'd0);

        // full sweep: groups x sub-ops x counts x registers x images
        for (int p = 0; p < 3; p++) begin
            for (int g = 0; g < 3; g++) begin
                for (int s = 0; s < 4; s++) begin
                    for (int cnt = 0; cnt < 16; cnt++) begin
                        for (int ri = 0; ri < 3; ri++) begin
                            for (int i = 0; i < 8; i++) load_reg(i, pattern(p, i));
                            load_carry(1'((p + cnt + ri) % 2));
                            model(g, rsel[ri], s, cnt);
                            issue(mk_instr(g, rsel[ri], s, cnt), lat);
                            if (g == 0) begin
                                case (s)
                                    0: begin tgt = "R2 add";   freq = "R2 flags"; end
                                    1: begin tgt = "R3 sub";   freq = "R3 flags"; end
                                    2: begin tgt = "R4 bic";   freq = "R4 flags"; end
                                    default: begin tgt = "R1 R4 load"; freq = "R4 flags"; end
                                endcase
                                check("R9 latency const", 32'(lat), 32'd1);
                            end else begin
                                if (g == 2) tgt = "R7 pair";
                                else if (s < 2) tgt = "R5 rotate";
                                else tgt = "R6 shift";
                                freq = "R8 flags";
                                check("R9 latency shift", 32'(lat), 32'(cnt + 1));
                            end
                            compare_all(tgt, rsel[ri], (rsel[ri] + 1) % 8, g == 2, freq);
                            commit();
                        end
                    end
                end
            end
        end

        // R10: unrecognised major opcodes
        begin
            logic [6:0] bad_maj [5];
            bad_maj[0] = 7'h00; bad_maj[1] = 7'h05; bad_maj[2] = 7'h45;
            bad_maj[3] = 7'h46; bad_maj[4] = 7'h7F;
            for (int j = 0; j < 5; j++) begin
                for (int i = 0; i < 8; i++) load_reg(i, pattern(2, i));
                model(0, 0, 0, 0);
                for (int i = 0; i < 8; i++) e[i] = m[i];
                en = mn; ez = mz; ev = mv; ec = mc;
                issue({bad_maj[j], 3'd3, 2'd1, 4'd7}, lat);
                check("R10 latency", 32'(lat), 32'd0);
                compare_all("R10 no write", 3, 4, 1'b0, "R10 flags kept");
            end
        end

        // R11: start pulse while busy is ignored
        for (int i = 0; i < 8; i++) load_reg(i, pattern(2, i));
        load_carry(1'b1);
        model(2, 2, 0, 15);
        @(negedge clk);
        instr = mk_instr(2, 2, 0, 15); start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        check("R11 busy raised", {31'd0, busy}, 32'd1);
        repeat (3) @(negedge clk);
        instr = mk_instr(0, 5, 3, 9); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 0;
        while (!done && lat < 40) begin @(negedge clk); lat++; end
        compare_all("R11 first op", 2, 3, 1'b1, "R11 flags");
        @(negedge clk);
        check("R11 busy falls", {31'd0, busy}, 32'd0);
        repeat (3) @(negedge clk);
        check("R11 second start dropped", 32'(regs_flat[5*16 +: 16]), 32'(e[5]));
        commit();

        // R12: load port blocked while busy
        issue(mk_instr(1, 0, 2, 15), lat);
        model(1, 0, 2, 15);
        @(negedge clk);
        instr = mk_instr(1, 1, 3, 15); start = 1'b1;
        @(negedge clk);
        start = 1'b0; ld_en = 1'b1; ld_sel = 3'd6; ld_data = 16'hDEAD;
        @(negedge clk);
        ld_en = 1'b0;
        lat = 0;
        while (!done && lat < 40) begin @(negedge clk); lat++; end
        check("R12 load ignored while busy", 32'(regs_flat[6*16 +: 16]), 32'(m[6]));

        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule